// File: doc/BRIEF.md
# Memory-Mapped Keyboard Input Port

This peripheral sits on a simple processor bus and answers reads at one fixed memory address. Key codes from the keyboard side arrive on an 8-bit input with a one-cycle valid strobe. They are held in a small first-in, first-out store until the processor collects them.

A read is recognised when three things hold at once: the address equals the port address, the memory-select line is high, and the read/not-write line is high. While such a read lasts, the port drives the oldest stored code onto its data output and raises the output enable. One clock later it raises ready, telling the processor that the data can be taken.

Each read cycle removes exactly one code from the store. A read from an empty store returns zero. A code that arrives while the store is full is lost, and a sticky overrun flag records the loss.

Top module: `kbd_mmio_port`

## Requirements
- R1: A read is decoded only when `bus_addr` equals 16'hFF00, `bus_mem_sel` is 1 and `bus_rd_nwr` is 1. `bus_doe` is 1 in exactly those cycles.
- R2: Whenever no read is decoded, `bus_doe` is 0 and `bus_dout` is 0.
- R3: Codes are returned in arrival order. Up to 8 codes can be held.
- R4: A decoded read removes exactly one code, at its first cycle. Holding the read for several cycles neither removes more codes nor changes `bus_dout`.
- R5: A read while the store is empty drives code 0 and still raises ready.
- R6: `bus_ready` is 1 from the cycle after a read is first decoded until the cycle after the read ends. It is 0 at all other times.
- R7: A code presented while 8 codes are held is dropped, even in a cycle where a read removes one, and `overrun` goes to 1. It stays at 1 until reset.
- R8: Accesses to 16'hFF00 with `bus_rd_nwr` at 0 (writes) change no state. Neither does any access with `bus_mem_sel` at 0.
- R9: After reset the store is empty, and `overrun`, `bus_ready` and `bus_doe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_code | input | 8 | Key code from keyboard side |
| key_valid | input | 1 | One-cycle strobe qualifying `key_code` |
| bus_addr | input | 16 | Processor address |
| bus_mem_sel | input | 1 | Memory access select |
| bus_rd_nwr | input | 1 | 1 = read, 0 = write |
| bus_dout | output | 8 | Read data, zero when not driven |
| bus_doe | output | 1 | Data output enable |
| bus_ready | output | 1 | Read data can be taken |
| overrun | output | 1 | Sticky flag, a code was dropped |

## Verification
The hardest situation to reach is a full store meeting a new key in the same cycle that a read starts. Pushing eight codes alone is not enough. The bench fills the store, then presents a ninth code together with the first cycle of a read. It checks that the code is dropped, the flag is set, and the eight stored codes come back in order followed by a zero.

A further case is a read held for several cycles. The bench holds it, then checks with a second read that only one code was consumed.

// File: rtl/kbd_mmio_port.sv
module kbd_mmio_port #(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 8,
  parameter int DEPTH = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] key_code,
  input  logic              key_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_mem_sel,
  input  logic              bus_rd_nwr,
  output logic [CODE_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              bus_ready,
  output logic              overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic [CODE_W-1:0] store_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fill;
  logic              rd_q, ovr_q;
  logic [CODE_W-1:0] hold_q;

  wire rd_hit   = (bus_addr == PORT_ADDR) && bus_mem_sel && bus_rd_nwr;
  wire rd_start = rd_hit && !rd_q;
  wire empty    = (fill == '0);
  wire full     = (fill == FULLC);
  wire push     = key_valid && !full;
  wire pop      = rd_start && !empty;
  wire [CODE_W-1:0] peek = empty ? '0 : store_q[rd_ptr];

  always_ff @(posedge clk)
    if (push) store_q[wr_ptr] <= key_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      rd_q   <= 1'b0;
      ovr_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      rd_q <= rd_hit;
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
      if (key_valid && full) ovr_q <= 1'b1;
      if (rd_start) hold_q <= peek;
    end
  end

  assign bus_doe   = rd_hit;
  assign bus_dout  = !rd_hit ? '0 : (rd_q ? hold_q : peek);
  assign bus_ready = rd_q;
  assign overrun   = ovr_q;
endmodule

// File: rtl/kbd_mmio_port_chk.sv
module kbd_mmio_port_chk #(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hFF00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_mem_sel,
  input logic              bus_rd_nwr,
  input logic [CODE_W-1:0] bus_dout,
  input logic              bus_doe,
  input logic              bus_ready,
  input logic              overrun
);
  assert_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (bus_addr == PORT_ADDR && bus_mem_sel && bus_rd_nwr));

  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_doe |-> (bus_dout == '0));

  assert_stable_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_doe && $past(bus_doe)) |-> $stable(bus_dout));

  assert_ready_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_doe) |-> bus_ready);

  assert_ready_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_doe) |-> !bus_ready);

  assert_sticky_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overrun) |-> overrun);
endmodule

bind kbd_mmio_port kbd_mmio_port_chk #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .PORT_ADDR(PORT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_mem_sel(bus_mem_sel),
  .bus_rd_nwr(bus_rd_nwr), .bus_dout(bus_dout), .bus_doe(bus_doe),
  .bus_ready(bus_ready), .overrun(overrun)
);

// File: tb/kbd_mmio_port_tb.sv
`timescale 1ns/1ps
module kbd_mmio_port_tb;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  key_code = 0;
  logic        key_valid = 0;
  logic [15:0] bus_addr = 0;
  logic        bus_mem_sel = 0, bus_rd_nwr = 0;
  logic [7:0]  bus_dout;
  logic        bus_doe, bus_ready, overrun;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  kbd_mmio_port u_dut (
    .clk(clk), .rst_n(rst_n), .key_code(key_code), .key_valid(key_valid),
    .bus_addr(bus_addr), .bus_mem_sel(bus_mem_sel), .bus_rd_nwr(bus_rd_nwr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_ready(bus_ready), .overrun(overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] c);
    @(posedge clk); #1;
    key_code = c; key_valid = 1;
    @(posedge clk); #1;
    key_valid = 0;
  endtask

  task automatic bus_read(input int hold, output logic [7:0] val);
    @(posedge clk); #1;
    bus_addr = 16'hFF00; bus_mem_sel = 1; bus_rd_nwr = 1;
    @(negedge clk);
    check("R1 doe on decode", bus_doe, 1);
    check("R6 ready low first cycle", bus_ready, 0);
    val = bus_dout;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R6 ready during read", bus_ready, 1);
      check("R4 data stable", bus_dout, val);
    end
    @(posedge clk); #1;
    bus_mem_sel = 0; bus_rd_nwr = 0; bus_addr = 0;
    @(negedge clk);
    check("R2 doe off", bus_doe, 0);
    check("R2 dout zero", bus_dout, 0);
    check("R6 ready tail", bus_ready, 1);
    @(negedge clk);
    check("R6 ready drop", bus_ready, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 doe", bus_doe, 0);
    check("R9 ready", bus_ready, 0);
    check("R9 overrun", overrun, 0);
    check("R2 dout", bus_dout, 0);
  endtask

  task automatic t_empty();
    logic [7:0] v;
    bus_read(1, v);
    check("R5 empty read", v, 0);
  endtask

  task automatic t_order();
    logic [7:0] v;
    push(8'h1C); push(8'h32); push(8'hA5);
    bus_read(1, v); check("R3 first", v, 8'h1C);
    bus_read(1, v); check("R3 second", v, 8'h32);
    bus_read(1, v); check("R3 third", v, 8'hA5);
    bus_read(1, v); check("R5 drained", v, 0);
  endtask

  task automatic t_long_read();
    logic [7:0] v;
    push(8'h41); push(8'h42);
    bus_read(5, v); check("R4 long read value", v, 8'h41);
    bus_read(1, v); check("R4 single pop", v, 8'h42);
    bus_read(1, v); check("R4 empty after", v, 0);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    push(8'h77);
    @(posedge clk); #1;
    bus_addr = 16'hFF01; bus_mem_sel = 1; bus_rd_nwr = 1;
    @(negedge clk); check("R1 wrong addr", bus_doe, 0);
    @(posedge clk); #1;
    bus_addr = 16'hFF00; bus_mem_sel = 0; bus_rd_nwr = 1;
    @(negedge clk); check("R1 no mem_sel", bus_doe, 0);
    @(posedge clk); #1;
    bus_addr = 16'hFF00; bus_mem_sel = 1; bus_rd_nwr = 0;
    @(negedge clk); check("R8 write no doe", bus_doe, 0);
    check("R8 write no dout", bus_dout, 0);
    @(posedge clk); #1;
    bus_mem_sel = 0; bus_addr = 0;
    @(negedge clk); check("R6 no ready after ignored", bus_ready, 0);
    bus_read(1, v); check("R8 code kept", v, 8'h77);
    bus_read(1, v); check("R8 nothing extra", v, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
    @(negedge clk); check("R7 no overrun at 8", overrun, 0);
    @(posedge clk); #1;
    key_code = 8'hEE; key_valid = 1;
    bus_addr = 16'hFF00; bus_mem_sel = 1; bus_rd_nwr = 1;
    @(negedge clk); v = bus_dout;
    check("R3 head while full", v, 8'h10);
    @(posedge clk); #1;
    key_valid = 0; bus_mem_sel = 0; bus_rd_nwr = 0; bus_addr = 0;
    @(negedge clk); check("R7 overrun set", overrun, 1);
    @(negedge clk);
    for (int i = 1; i < 8; i++) begin
      bus_read(1, v); check("R7 R3 kept order", v, 8'h10 + 8'(i));
    end
    bus_read(1, v); check("R7 dropped code", v, 0);
    check("R7 sticky", overrun, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_empty();
    t_order();
    t_long_read();
    t_ignored();
    t_overrun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule